// File: doc/BRIEF.md
# Communication Buffer Transfer Controller

This block moves one burst of bytes between a 128-byte scratch buffer and one of four serial channels. Software fills the buffer through 32 word registers, then sets the start bit in a single control word. The control word also carries the channel number and two length fields. The controller streams the outgoing bytes to the selected channel over a valid/ready byte handshake. It then collects the response bytes into the same buffer, starting at byte 0, and raises a transfer-complete flag.

A response that stops arriving is caught by a programmable idle timeout. The timeout ends the transfer with the communication-error bit set, and the transfer-complete flag is still raised. Software can cancel a running transfer by writing 0 to the start bit. A second flag, read-status, latches a pulse from the channel side. Each flag has its own mask, and the two masked flags combine into one interrupt line.

Top module: `commbuf_xfer`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0, the timeout word (offset 0x04) reads 255, every buffer word reads 0, and irq and out_valid are low.
- R2: The input length (control bits 14:8) and the output length (control bits 22:16) are decoded as follows. A field value of 0 means 128 bytes, and any other value N means N+1 bytes.
- R3: Writing the control word with bit 0 set while idle starts a transfer, and bit 0 reads 1 until the transfer ends. The output-length bytes are sent in order from buffer byte 0. Buffer byte k is bits 8*(k%4)+7:8*(k%4) of the word at offset 0x80+4*(k/4).
- R4: After the last output byte is accepted, each in_valid cycle stores in_byte at the next buffer byte, starting from byte 0. Bytes beyond the input length are left unchanged, and in_valid is ignored while bytes are still being sent.
- R5: The clock edge that accepts the last input byte clears bit 0 and sets the transfer-complete flag (bit 31).
- R6: With timeout value L, L+1 consecutive receive cycles without in_valid end the transfer. This sets the communication-error bit (bit 29) and bit 31, and clears bit 0.
- R7: Writing the control word with bit 0 clear while busy cancels the transfer. From the next cycle, bit 0 and out_valid are low and bit 31 is not set.
- R8: A control write with bit 31 set clears the transfer-complete flag, and one with bit 28 set clears the read-status flag. The clear is applied before a transfer started by the same write, and writing 0 to these bits changes nothing.
- R9: Any control write clears bit 29.
- R10: While busy, control writes leave the channel and both length fields unchanged, and writes to buffer words and to the timeout word are ignored.
- R11: A pulse on rd_event sets the read-status flag (bit 28). irq is high exactly when (bit 31 and mask bit 30) or (bit 28 and mask bit 27).
- R12: chan_sel always shows the channel field (control bits 2:1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| chan_sel | output | 2 | Selected serial channel |
| out_valid | output | 1 | Outgoing byte valid |
| out_byte | output | 8 | Outgoing byte |
| out_ready | input | 1 | Channel accepts the outgoing byte |
| in_valid | input | 1 | Response byte valid |
| in_byte | input | 8 | Response byte |
| rd_event | input | 1 | Pulse: a channel has new read data |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong byte index shows up in the first out_byte after start, or in the buffer readback once the transfer ends. A miscounted length moves the cycle in which bit 0 falls, and that cycle can be predicted exactly from the handshakes. A timeout counter that is off by one changes the number of cycles busy stays high after the last response byte, so the check counts those cycles rather than just waiting for the end. Stale flag or mask state appears on irq in the cycle after the control write that should have changed it.

// File: rtl/commbuf_pkg.sv
package commbuf_pkg;
    localparam int BUF_BYTES = 128;
    localparam int IDX_W     = $clog2(BUF_BYTES);
    localparam int LEN_W     = IDX_W + 1;
    localparam int WORDS     = BUF_BYTES / 4;
    localparam int WIDX_W    = $clog2(WORDS);
    localparam int CHAN_W    = 2;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SEND,
        ENG_RECV
    } eng_state_e;

    // field value 0 stands for the full buffer, N for N+1 bytes
    function automatic logic [LEN_W-1:0] decode_len(input logic [IDX_W-1:0] f);
        if (f == '0) return LEN_W'(BUF_BYTES);
        return LEN_W'({1'b0, f}) + LEN_W'(1);
    endfunction
endpackage

// File: rtl/commbuf_store.sv
module commbuf_store #(
    parameter int BYTES = 128,
    localparam int IDX_W = $clog2(BYTES),
    localparam int WORDS = BYTES / 4,
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [WIDX_W-1:0] cpu_widx,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    input  logic              eng_we,
    input  logic [IDX_W-1:0]  eng_widx,
    input  logic [7:0]        eng_wbyte,
    input  logic [IDX_W-1:0]  eng_ridx,
    output logic [7:0]        eng_rbyte
);
    typedef struct packed {
        logic [BYTES-1:0][7:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cpu_we) begin
            for (int b = 0; b < 4; b++) begin
                st_d.mem[{cpu_widx, 2'(b)}] = cpu_wdata[8*b +: 8];
            end
        end
        if (eng_we) begin
            st_d.mem[eng_widx] = eng_wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign cpu_rdata[8*g +: 8] = st_q.mem[{cpu_widx, 2'(g)}];
    end

    assign eng_rbyte = st_q.mem[eng_ridx];
endmodule

// File: rtl/commbuf_engine.sv
module commbuf_engine
    import commbuf_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [LEN_W-1:0] out_len,
    input  logic [LEN_W-1:0] in_len,
    input  logic [TMO_W-1:0] limit,
    output logic             busy,
    output logic             out_valid,
    input  logic             out_ready,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_byte,
    output logic             done,
    output logic             timed_out
);
    typedef struct packed {
        eng_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [TMO_W-1:0] timer;
    } eng_t;

    eng_t e_d, e_q;
    logic last_out, last_in;

    assign last_out = ({1'b0, e_q.idx} == out_len - LEN_W'(1));
    assign last_in  = ({1'b0, e_q.idx} == in_len - LEN_W'(1));

    always_comb begin
        e_d       = e_q;
        done      = 1'b0;
        timed_out = 1'b0;
        wr_en     = 1'b0;
        unique case (e_q.state)
            ENG_IDLE: begin
                if (start) begin
                    e_d.state = ENG_SEND;
                    e_d.idx   = '0;
                end
            end
            ENG_SEND: begin
                if (abort) begin
                    e_d.state = ENG_IDLE;
                end else if (out_ready) begin
                    if (last_out) begin
                        e_d.state = ENG_RECV;
                        e_d.idx   = '0;
                        e_d.timer = '0;
                    end else begin
                        e_d.idx = e_q.idx + IDX_W'(1);
                    end
                end
            end
            ENG_RECV: begin
                if (abort) begin
                    e_d.state = ENG_IDLE;
                end else if (in_valid) begin
                    wr_en     = 1'b1;
                    e_d.timer = '0;
                    if (last_in) begin
                        e_d.state = ENG_IDLE;
                        done      = 1'b1;
                    end else begin
                        e_d.idx = e_q.idx + IDX_W'(1);
                    end
                end else if (e_q.timer == limit) begin
                    e_d.state = ENG_IDLE;
                    timed_out = 1'b1;
                end else begin
                    e_d.timer = e_q.timer + TMO_W'(1);
                end
            end
            default: e_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{state: ENG_IDLE, idx: '0, timer: '0};
        else        e_q <= e_d;
    end

    assign busy      = (e_q.state != ENG_IDLE);
    assign out_valid = (e_q.state == ENG_SEND);
    assign rd_idx    = e_q.idx;
    assign wr_idx    = e_q.idx;
    assign wr_byte   = in_byte;
endmodule

// File: rtl/commbuf_xfer.sv
module commbuf_xfer
    import commbuf_pkg::*;
#(
    parameter int          TMO_W     = 16,
    parameter int unsigned TMO_RESET = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    input  logic              out_ready,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              rd_event,
    output logic              irq
);
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_TMO  = 8'h04;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [IDX_W-1:0]  in_f;
        logic [IDX_W-1:0]  out_f;
        logic              rd_mask;
        logic              rd_flag;
        logic              err;
        logic              tc_mask;
        logic              tc_flag;
        logic [TMO_W-1:0]  tmo;
    } csr_t;

    csr_t c_d, c_q;

    logic              busy, eng_done, eng_tmo;
    logic              sel_ctrl, sel_tmo, sel_buf;
    logic              ctrl_wr, tmo_wr, buf_wr;
    logic              start, abort;
    logic [31:0]       buf_rdata, ctrl_word;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic              wr_en;
    logic [7:0]        wr_byte;
    logic              unused_bits;

    assign sel_ctrl = (bus_addr == A_CTRL);
    assign sel_tmo  = (bus_addr == A_TMO);
    assign sel_buf  = bus_addr[7] && (bus_addr[1:0] == 2'b00);
    assign ctrl_wr  = bus_wr && sel_ctrl;
    assign tmo_wr   = bus_wr && sel_tmo && !busy;
    assign buf_wr   = bus_wr && sel_buf && !busy;
    assign start    = ctrl_wr && bus_wdata[0] && !busy;
    assign abort    = ctrl_wr && !bus_wdata[0] && busy;

    always_comb begin
        c_d = c_q;
        if (ctrl_wr) begin
            c_d.err     = 1'b0;
            c_d.rd_mask = bus_wdata[27];
            c_d.tc_mask = bus_wdata[30];
            if (bus_wdata[31]) c_d.tc_flag = 1'b0;
            if (bus_wdata[28]) c_d.rd_flag = 1'b0;
            if (!busy) begin
                c_d.chan  = bus_wdata[2:1];
                c_d.in_f  = bus_wdata[8 +: IDX_W];
                c_d.out_f = bus_wdata[16 +: IDX_W];
            end
        end
        if (tmo_wr)   c_d.tmo     = bus_wdata[TMO_W-1:0];
        if (rd_event) c_d.rd_flag = 1'b1;
        if (eng_done) c_d.tc_flag = 1'b1;
        if (eng_tmo) begin
            c_d.tc_flag = 1'b1;
            c_d.err     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.tmo <= TMO_W'(TMO_RESET);
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[0]             = busy;
        ctrl_word[2:1]           = c_q.chan;
        ctrl_word[8 +: IDX_W]    = c_q.in_f;
        ctrl_word[16 +: IDX_W]   = c_q.out_f;
        ctrl_word[27]            = c_q.rd_mask;
        ctrl_word[28]            = c_q.rd_flag;
        ctrl_word[29]            = c_q.err;
        ctrl_word[30]            = c_q.tc_mask;
        ctrl_word[31]            = c_q.tc_flag;
    end

    always_comb begin
        if (sel_buf)       bus_rdata = buf_rdata;
        else if (sel_ctrl) bus_rdata = ctrl_word;
        else if (sel_tmo)  bus_rdata = {{(32-TMO_W){1'b0}}, c_q.tmo};
        else               bus_rdata = '0;
    end

    assign unused_bits = ^{bus_wdata[7:3], bus_wdata[15], bus_wdata[26:23],
                           bus_wdata[31:TMO_W]};

    commbuf_store #(.BYTES(BUF_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_we   (buf_wr),
        .cpu_widx (bus_addr[2 +: WIDX_W]),
        .cpu_wdata(bus_wdata),
        .cpu_rdata(buf_rdata),
        .eng_we   (wr_en),
        .eng_widx (wr_idx),
        .eng_wbyte(wr_byte),
        .eng_ridx (rd_idx),
        .eng_rbyte(out_byte)
    );

    commbuf_engine #(.TMO_W(TMO_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .abort    (abort),
        .out_len  (decode_len(c_q.out_f)),
        .in_len   (decode_len(c_q.in_f)),
        .limit    (c_q.tmo),
        .busy     (busy),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_byte  (wr_byte),
        .done     (eng_done),
        .timed_out(eng_tmo)
    );

    assign chan_sel = c_q.chan;
    assign irq      = (c_q.tc_flag && c_q.tc_mask) || (c_q.rd_flag && c_q.rd_mask);
endmodule

// File: rtl/commbuf_xfer_chk.sv
module commbuf_xfer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       out_valid,
    input logic [1:0] chan_sel,
    input logic       tc_flag,
    input logic       err_flag,
    input logic       tc_mask,
    input logic       rd_mask,
    input logic       ctrl_wr,
    input logic       wdata0,
    input logic       irq
);
    // R3: bytes leave only during a transfer
    p_out_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    // R5: completion flag rises only as busy falls
    p_tc_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_flag) |-> (!busy && $past(busy)));

    // R6: an error ends the transfer and still reports completion
    p_err_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (tc_flag && !busy));

    // R7: cancel ends busy on the next cycle without completion
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wdata0 && busy) |=> (!busy && !$rose(tc_flag)));

    // R10: channel held for the whole transfer
    p_chan_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(chan_sel));

    // R11: both masks clear keeps irq low
    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tc_mask && !rd_mask) |-> !irq);
endmodule

bind commbuf_xfer commbuf_xfer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .out_valid(out_valid),
    .chan_sel (chan_sel),
    .tc_flag  (c_q.tc_flag),
    .err_flag (c_q.err),
    .tc_mask  (c_q.tc_mask),
    .rd_mask  (c_q.rd_mask),
    .ctrl_wr  (ctrl_wr),
    .wdata0   (bus_wdata[0]),
    .irq      (irq)
);

// File: tb/commbuf_xfer_bench.sv
module commbuf_xfer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  chan_sel;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        out_ready = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        rd_event = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_buf [128];

    always #10 clk = ~clk;

    commbuf_xfer u_commbuf_xfer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_sel(chan_sel),
        .out_valid(out_valid), .out_byte(out_byte), .out_ready(out_ready),
        .in_valid(in_valid), .in_byte(in_byte), .rd_event(rd_event), .irq(irq)
    );

    function automatic int exp_len(input logic [6:0] f);
        return (f == 0) ? 128 : int'(f) + 1;
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic st, input logic [1:0] ch,
        input logic [6:0] inf, input logic [6:0] outf, input logic rdm,
        input logic tcm, input logic clr_rd, input logic clr_tc);
        logic [31:0] v = '0;
        v[0] = st; v[2:1] = ch; v[14:8] = inf; v[22:16] = outf;
        v[27] = rdm; v[28] = clr_rd; v[30] = tcm; v[31] = clr_tc;
        return v;
    endfunction

    function automatic logic [31:0] exp_word(input int w);
        return {exp_buf[4*w+3], exp_buf[4*w+2], exp_buf[4*w+1], exp_buf[4*w]};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic fill_buf();
        for (int w = 0; w < 32; w++) begin
            logic [31:0] d = $urandom;
            wr(8'h80 + 8'(4*w), d);
            for (int b = 0; b < 4; b++) exp_buf[4*w+b] = d[8*b +: 8];
        end
    endtask

    task automatic check_buf(input string tag);
        logic [31:0] d;
        int miss = 0;
        logic [31:0] first_a = '0, first_e = '0;
        for (int w = 0; w < 32; w++) begin
            rd(8'h80 + 8'(4*w), d);
            if (d !== exp_word(w) && miss == 0) begin
                first_a = d; first_e = exp_word(w);
            end
            if (d !== exp_word(w)) miss++;
        end
        chk(first_a, first_e, tag);
    endtask

    task automatic run_xfer(input logic [1:0] ch, input logic [6:0] outf,
                            input logic [6:0] inf, input logic tcm);
        int outn = exp_len(outf);
        int inn = exp_len(inf);
        int sent = 0, rcvd = 0, mism = 0;
        logic [31:0] d;
        wr(8'h00, mk_ctrl(1'b1, ch, inf, outf, 1'b0, tcm, 1'b1, 1'b1));
        rd(8'h00, d);
        chk({31'd0, d[0]}, 32'd1, "R3 busy after start");
        chk({31'd0, d[31]}, 32'd0, "R8 flag cleared before start");
        chk({30'd0, chan_sel}, {30'd0, ch}, "R12 channel select");
        while (rcvd < inn) begin
            @(negedge clk);
            if (sent < outn) begin
                out_ready = 1'($urandom);
                in_valid  = 1'($urandom);
                in_byte   = 8'($urandom);
                if (out_valid && out_ready) begin
                    if (out_byte !== exp_buf[sent]) mism++;
                    sent++;
                end
            end else begin
                out_ready = 1'b0;
                in_valid  = ($urandom % 3) != 0;
                if (in_valid) begin
                    in_byte = 8'($urandom);
                    exp_buf[rcvd] = in_byte;
                    rcvd++;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        rd(8'h00, d);
        chk({31'd0, d[0]}, 32'd0, "R5 busy cleared at last byte");
        chk({31'd0, d[31]}, 32'd1, "R5 transfer-complete set");
        chk({31'd0, irq}, {31'd0, tcm}, "R11 irq follows masked flag");
        chk(32'(mism), 32'd0, "R3 R2 outgoing byte order and count");
        check_buf("R4 R2 received bytes in buffer");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, d); chk(d, 32'd0, "R1 control word");
        rd(8'h04, d); chk(d, 32'd255, "R1 timeout word");
        rd(8'h94, d); chk(d, 32'd0, "R1 buffer word");
        chk({30'd0, irq, out_valid}, 32'd0, "R1 irq and out_valid");
        for (int i = 0; i < 128; i++) exp_buf[i] = 8'h00;

        wr(8'h04, 32'd200);

        // directed lengths, including both encodings of 128
        fill_buf();
        run_xfer(2'd2, 7'd0, 7'd0, 1'b1);
        fill_buf();
        run_xfer(2'd1, 7'd1, 7'd127, 1'b0);
        run_xfer(2'd3, 7'd127, 7'd1, 1'b1);

        // random transfers
        for (int it = 0; it < 10; it++) begin
            logic [6:0] of = ($urandom % 6 == 0) ? 7'd0 : 7'($urandom % 40);
            logic [6:0] inf = ($urandom % 6 == 0) ? 7'd0 : 7'($urandom % 40);
            if (it % 3 == 0) fill_buf();
            run_xfer(2'($urandom), of, inf, 1'($urandom));
        end

        // R6 exact timeout window
        wr(8'h04, 32'd5);
        fill_buf();
        wr(8'h00, mk_ctrl(1'b1, 2'd0, 7'd3, 7'd1, 1'b0, 1'b1, 1'b1, 1'b1));
        n = 0;
        while (n < 2) begin
            @(negedge clk);
            out_ready = 1'b1;
            if (out_valid) n++;
        end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            out_ready = 1'b0;
            in_valid = 1'b1;
            in_byte = 8'hA0 + 8'(k);
            exp_buf[k] = in_byte;
        end
        @(negedge clk);
        in_valid = 1'b0;
        n = 0;
        rd(8'h00, d);
        while (d[0] && n < 100) begin
            n++;
            @(negedge clk);
            rd(8'h00, d);
        end
        chk(32'(n), 32'd6, "R6 idle cycles before timeout");
        chk({29'd0, d[31], d[29], d[0]}, 32'b110, "R6 error and complete set");
        chk({31'd0, irq}, 32'd1, "R11 irq on timeout completion");
        rd(8'h80, d); chk(d, exp_word(0), "R6 partial response kept");

        // R9 any write clears error; R8 zero leaves the flag
        wr(8'h00, mk_ctrl(1'b0, 2'd0, 7'd3, 7'd1, 1'b0, 1'b0, 1'b0, 1'b0));
        rd(8'h00, d);
        chk({30'd0, d[31], d[29]}, 32'b10, "R9 error cleared R8 flag kept");
        wr(8'h04, 32'd200);

        // R10 ignored writes while busy, then R7 cancel
        out_ready = 1'b0;
        wr(8'h00, mk_ctrl(1'b1, 2'd1, 7'd9, 7'd4, 1'b0, 1'b0, 1'b0, 1'b1));
        wr(8'hFC, 32'hDEADBEEF);
        wr(8'h04, 32'd9);
        wr(8'h00, mk_ctrl(1'b1, 2'd3, 7'd20, 7'd30, 1'b0, 1'b0, 1'b0, 1'b0));
        rd(8'h00, d);
        chk({d[22:16], 1'b0, d[14:8], d[2:0]}, {7'd4, 1'b0, 7'd9, 3'b011}, "R10 fields frozen");
        chk({30'd0, chan_sel}, 32'd1, "R10 chan_sel frozen");
        wr(8'h00, mk_ctrl(1'b0, 2'd2, 7'd5, 7'd5, 1'b0, 1'b0, 1'b0, 1'b0));
        rd(8'h00, d);
        chk({30'd0, d[31], d[0]}, 32'd0, "R7 cancel without completion");
        chk({31'd0, out_valid}, 32'd0, "R7 out_valid low after cancel");
        rd(8'hFC, d); chk(d, exp_word(31), "R10 buffer write ignored");
        rd(8'h04, d); chk(d, 32'd200, "R10 timeout write ignored");

        // R11 read-status flag and mask
        wr(8'h00, mk_ctrl(1'b0, 2'd0, 7'd0, 7'd0, 1'b0, 1'b0, 1'b1, 1'b1));
        @(negedge clk); rd_event = 1'b1;
        @(negedge clk); rd_event = 1'b0;
        rd(8'h00, d);
        chk({30'd0, d[28], irq}, 32'b10, "R11 flag set, mask off");
        wr(8'h00, mk_ctrl(1'b0, 2'd0, 7'd0, 7'd0, 1'b1, 1'b0, 1'b0, 1'b0));
        chk({31'd0, irq}, 32'd1, "R11 irq with mask");
        wr(8'h00, mk_ctrl(1'b0, 2'd0, 7'd0, 7'd0, 1'b1, 1'b0, 1'b1, 1'b0));
        rd(8'h00, d);
        chk({30'd0, d[28], irq}, 32'b00, "R8 write-one clears read flag");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule